// File: doc/BRIEF.md
# Operand Shifter with Carry

This block is a purely combinational shifter for the second source operand of a 32-bit integer datapath. It takes a data word, a shift-kind code, a shift amount and the current carry flag, and returns the shifted word together with a shifter carry that the flag-update logic can use. Five kinds are offered: logical left, logical right, arithmetic right, rotate right, and a one-position rotate right through the carry flag (33 bits in total). Arithmetic left is not offered because it is identical to logical left.

The shift amount is taken either from a 5-bit immediate field or from the low byte of a register. A register amount can reach 255, so behaviour for amounts of 32 and above is fully defined. An input flag selects a special reading of a zero immediate. Under that reading a right shift by 0 means a shift by the full width, and a rotate by 0 means the rotate through carry. The shifted word goes straight to an adder. A value plus itself shifted left by two must therefore give five times the value.

Top module: `operand_shifter`

## Requirements
- R1: `kind_i` is coded 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, 4 = rotate right through carry. Codes 5 to 7 return `op_a_i` unchanged with `carry_o` equal to `carry_i`.
- R2: With `use_reg_amt_i` = 1, the amount is the 8-bit `reg_amt_i` and `imm_amt_i` has no effect. With `use_reg_amt_i` = 0, the amount is the 5-bit `imm_amt_i` and `reg_amt_i` has no effect.
- R3: For codes 0 to 3, an effective amount of zero returns `op_a_i` unchanged, with `carry_o` equal to `carry_i`.
- R4: Logical left by n (1 to 31) fills zeros from the bottom, and `carry_o` is bit 32-n of the input. By exactly 32 the result is zero and `carry_o` is input bit 0. Beyond 32 both the result and the carry are zero.
- R5: Logical right by n (1 to 31) fills zeros from the top, and `carry_o` is input bit n-1. By exactly 32 the result is zero and `carry_o` is input bit 31. Beyond 32 both the result and the carry are zero.
- R6: Arithmetic right by n (1 to 31) fills copies of input bit 31, and `carry_o` is input bit n-1. For n of 32 or more, every result bit and `carry_o` equal input bit 31.
- R7: Rotate right uses the amount modulo 32. For any nonzero amount, `carry_o` equals result bit 31. A nonzero multiple of 32 leaves the word unchanged.
- R8: Rotate through carry puts `carry_i` into result bit 31 and input bits 31..1 into result bits 30..0. `carry_o` is input bit 0, and the amount has no effect.
- R9: When `imm_zero_special_i` = 1, `use_reg_amt_i` = 0 and `imm_amt_i` = 0, logical right and arithmetic right act as a shift by 32, and rotate right acts as rotate through carry. Logical left is unaffected. When the flag is 0, or the amount comes from the register, a zero amount follows R3.
- R10: `op_a_i` plus the result of a logical left by 2 equals 5 × `op_a_i` modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 32 | Data word to shift |
| kind_i | input | 3 | Shift kind code (see R1) |
| use_reg_amt_i | input | 1 | 1 = amount from register byte, 0 = from immediate |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 8 | Low byte of a register, used as the shift amount |
| imm_zero_special_i | input | 1 | Enables the special reading of a zero immediate |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The embedded checks assume two-state inputs and a data width that is a power of two, because the rotate takes its amount modulo the width by dropping the upper amount bits. They also assume that the effective amount fits the 8-bit register field. The stimulus keeps to these limits. It sweeps every kind code, including the unused ones, over register amounts 0 to 40 plus 200 and 255, and over every immediate amount with the zero-immediate flag both clear and set. Both carry-in values and words with distinct bit patterns at the edges and the sign are used, so every window the checks watch is reached.

// File: rtl/shf_pkg.sv
package shf_pkg;

    // Width of the register-sourced amount field (low byte of a register).
    localparam int REG_AMT_W = 8;

    // Internal shift kinds after decode; PASS covers unused codes.
    typedef enum logic [2:0] {
        SHK_LSL  = 3'd0,
        SHK_LSR  = 3'd1,
        SHK_ASR  = 3'd2,
        SHK_ROR  = 3'd3,
        SHK_RRX  = 3'd4,
        SHK_PASS = 3'd7
    } shift_kind_e;

    // Decoded control carried from the decoder to the datapath.
    typedef struct packed {
        shift_kind_e              kind;
        logic [REG_AMT_W-1:0]     amt;
    } shift_ctl_t;

    function automatic shift_kind_e kind_from_code(input logic [2:0] code);
        case (code)
            3'd0:    return SHK_LSL;
            3'd1:    return SHK_LSR;
            3'd2:    return SHK_ASR;
            3'd3:    return SHK_ROR;
            3'd4:    return SHK_RRX;
            default: return SHK_PASS;
        endcase
    endfunction

endpackage

// File: rtl/shf_ctl_decode.sv
module shf_ctl_decode
    import shf_pkg::*;
#(
    parameter int IMM_W = 5
) (
    input  logic [2:0]           kind_i,
    input  logic                 use_reg_i,
    input  logic [IMM_W-1:0]     imm_amt_i,
    input  logic [REG_AMT_W-1:0] reg_amt_i,
    input  logic                 zero_special_i,
    output shift_ctl_t           ctl_o
);
    // Full data width expressed as an amount (2**IMM_W).
    localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(1 << IMM_W);

    logic imm_is_zero_special;

    always_comb begin
        imm_is_zero_special = zero_special_i && !use_reg_i && (imm_amt_i == '0);
        ctl_o.kind = kind_from_code(kind_i);
        ctl_o.amt  = use_reg_i ? reg_amt_i : REG_AMT_W'(imm_amt_i);
        if (imm_is_zero_special) begin
            case (ctl_o.kind)
                SHK_LSR, SHK_ASR: ctl_o.amt  = FULL_AMT;
                SHK_ROR:          ctl_o.kind = SHK_RRX;
                default:          ;
            endcase
        end
    end

endmodule

// File: rtl/shf_linear.sv
module shf_linear
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]    a_i,
    input  shift_kind_e          kind_i,
    input  logic [REG_AMT_W-1:0] amt_i,
    input  logic                 cin_i,
    output logic [DATA_W-1:0]    y_o,
    output logic                 cout_o
);
    // One guard bit catches the last bit shifted out; amounts are clamped
    // to one past the width so the shifter never grows with the amount.
    localparam int EXT_W = DATA_W + 1;
    localparam logic [REG_AMT_W-1:0] AMT_CAP = REG_AMT_W'(DATA_W + 1);

    logic [REG_AMT_W-1:0]    amt_c;
    logic [EXT_W-1:0]        left_w;
    logic [EXT_W-1:0]        right_l;
    logic signed [EXT_W-1:0] right_a;

    always_comb begin
        amt_c   = (amt_i > AMT_CAP) ? AMT_CAP : amt_i;
        left_w  = {1'b0, a_i} << amt_c;
        right_l = {a_i, 1'b0} >> amt_c;
        right_a = $signed({a_i, 1'b0}) >>> amt_c;
        y_o     = a_i;
        cout_o  = cin_i;
        if (amt_i != '0) begin
            case (kind_i)
                SHK_LSL: begin
                    y_o    = left_w[DATA_W-1:0];
                    cout_o = left_w[DATA_W];
                end
                SHK_LSR: begin
                    y_o    = right_l[EXT_W-1:1];
                    cout_o = right_l[0];
                end
                SHK_ASR: begin
                    y_o    = right_a[EXT_W-1:1];
                    cout_o = right_a[0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/shf_rotate.sv
module shf_rotate
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]    a_i,
    input  shift_kind_e          kind_i,
    input  logic [REG_AMT_W-1:0] amt_i,
    input  logic                 cin_i,
    output logic [DATA_W-1:0]    y_o,
    output logic                 cout_o
);
    localparam int ROT_W = $clog2(DATA_W);

    logic [ROT_W-1:0]  rot_amt;
    logic [DATA_W-1:0] rotated;

    always_comb begin
        rot_amt = amt_i[ROT_W-1:0];
        rotated = DATA_W'({a_i, a_i} >> rot_amt);
        y_o     = a_i;
        cout_o  = cin_i;
        case (kind_i)
            SHK_ROR: begin
                if (amt_i != '0) begin
                    y_o    = rotated;
                    cout_o = rotated[DATA_W-1];
                end
            end
            SHK_RRX: begin
                y_o    = {cin_i, a_i[DATA_W-1:1]};
                cout_o = a_i[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]    op_a_i,
    input  logic [2:0]           kind_i,
    input  logic                 use_reg_amt_i,
    input  logic [IMM_W-1:0]     imm_amt_i,
    input  logic [REG_AMT_W-1:0] reg_amt_i,
    input  logic                 imm_zero_special_i,
    input  logic                 carry_i,
    output logic [DATA_W-1:0]    result_o,
    output logic                 carry_o
);
    shift_ctl_t        ctl;
    logic [DATA_W-1:0] lin_y, rot_y;
    logic              lin_c, rot_c;

    shf_ctl_decode #(.IMM_W(IMM_W)) u_decode (
        .kind_i         (kind_i),
        .use_reg_i      (use_reg_amt_i),
        .imm_amt_i      (imm_amt_i),
        .reg_amt_i      (reg_amt_i),
        .zero_special_i (imm_zero_special_i),
        .ctl_o          (ctl)
    );

    shf_linear #(.DATA_W(DATA_W)) u_linear (
        .a_i    (op_a_i),
        .kind_i (ctl.kind),
        .amt_i  (ctl.amt),
        .cin_i  (carry_i),
        .y_o    (lin_y),
        .cout_o (lin_c)
    );

    shf_rotate #(.DATA_W(DATA_W)) u_rotate (
        .a_i    (op_a_i),
        .kind_i (ctl.kind),
        .amt_i  (ctl.amt),
        .cin_i  (carry_i),
        .y_o    (rot_y),
        .cout_o (rot_c)
    );

    always_comb begin
        case (ctl.kind)
            SHK_LSL, SHK_LSR, SHK_ASR: begin
                result_o = lin_y;
                carry_o  = lin_c;
            end
            SHK_ROR, SHK_RRX: begin
                result_o = rot_y;
                carry_o  = rot_c;
            end
            default: begin
                result_o = op_a_i;
                carry_o  = carry_i;
            end
        endcase
    end

    // Output properties checked against the decoded control.
    always_comb begin
        if (ctl.kind == SHK_PASS) begin
            assert_unused_code_pass_R1: assert (result_o == op_a_i && carry_o == carry_i)
                else $error("unused kind code altered the operand");
        end
        if (ctl.amt == '0 && (ctl.kind == SHK_LSL || ctl.kind == SHK_LSR ||
                              ctl.kind == SHK_ASR || ctl.kind == SHK_ROR)) begin
            assert_zero_amount_pass_R3: assert (result_o == op_a_i && carry_o == carry_i)
                else $error("zero amount altered the operand or carry");
        end
        if (ctl.kind == SHK_LSL && int'(ctl.amt) > DATA_W) begin
            assert_lsl_beyond_width_R4: assert (result_o == '0 && carry_o == 1'b0)
                else $error("left shift past width left bits behind");
        end
        if (ctl.kind == SHK_ASR) begin
            assert_asr_keeps_sign_R6: assert (result_o[DATA_W-1] == op_a_i[DATA_W-1])
                else $error("arithmetic right lost the sign bit");
        end
        if (ctl.kind == SHK_ROR && ctl.amt != '0) begin
            assert_ror_carry_is_msb_R7: assert (carry_o == result_o[DATA_W-1])
                else $error("rotate carry differs from result msb");
        end
        if (ctl.kind == SHK_RRX) begin
            assert_rrx_through_carry_R8: assert (result_o[DATA_W-1] == carry_i &&
                                                 carry_o == op_a_i[0])
                else $error("rotate through carry moved the wrong bits");
        end
    end

endmodule

// File: tb/operand_shifter_tb.sv
module operand_shifter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;

    logic [31:0] op_a = '0;
    logic [2:0]  kind = '0;
    logic        use_reg = 1'b0;
    logic [4:0]  imm_amt = '0;
    logic [7:0]  reg_amt = '0;
    logic        zspec = 1'b0;
    logic        cin = 1'b0;
    logic [31:0] result;
    logic        cout;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    operand_shifter dut_i (
        .op_a_i             (op_a),
        .kind_i             (kind),
        .use_reg_amt_i      (use_reg),
        .imm_amt_i          (imm_amt),
        .reg_amt_i          (reg_amt),
        .imm_zero_special_i (zspec),
        .carry_i            (cin),
        .result_o           (result),
        .carry_o            (cout)
    );

    // Behavioural model: one bit position per step, tracking the bit that leaves.
    function automatic void model(input int k, input logic [31:0] a, input int n,
                                  input bit ci, output logic [31:0] y, output bit co);
        y  = a;
        co = ci;
        case (k)
            0: for (int i = 0; i < n; i++) begin co = y[31]; y = {y[30:0], 1'b0}; end
            1: for (int i = 0; i < n; i++) begin co = y[0];  y = {1'b0, y[31:1]}; end
            2: for (int i = 0; i < n; i++) begin co = y[0];  y = {y[31], y[31:1]}; end
            3: if (n != 0) begin
                   for (int i = 0; i < n % 32; i++) y = {y[0], y[31:1]};
                   co = y[31];
               end
            4: begin co = a[0]; y = {ci, a[31:1]}; end
            default: ;
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] exp_y, input bit exp_c);
        checks++;
        if (result !== exp_y || cout !== exp_c) begin
            errors++;
            $display("FAIL %s kind=%0d reg=%0b imm=%0d ramt=%0d zs=%0b a=%h cin=%0b : got %h/%0b expected %h/%0b",
                     tag, kind, use_reg, imm_amt, reg_amt, zspec, op_a, cin,
                     result, cout, exp_y, exp_c);
        end
    endtask

    // Drive after the falling edge, check a quarter period later.
    task automatic run_one(input int k, input bit ur, input int ia, input int ra,
                           input bit zs, input logic [31:0] a, input bit ci);
        int          ek;
        int          en;
        logic [31:0] ey;
        bit          ec;
        string       tag;
        @(negedge clk);
        kind = 3'(k); use_reg = ur; imm_amt = 5'(ia); reg_amt = 8'(ra);
        zspec = zs; op_a = a; cin = ci;
        #(CLK_PERIOD/4);
        ek = k;
        en = ur ? ra : ia;
        if (ek == 0) tag = "R4";
        else if (ek == 1) tag = "R5";
        else if (ek == 2) tag = "R6";
        else if (ek == 3) tag = "R7";
        else if (ek == 4) tag = "R8";
        else tag = "R1";
        if (zs && !ur && ia == 0 && (ek >= 1 && ek <= 3)) begin
            tag = "R9";
            if (ek == 3) ek = 4; else en = 32;
        end else if (en == 0 && ek <= 3) begin
            tag = "R3";
        end
        model(ek, a, en, ci, ey, ec);
        compare(tag, ey, ec);
    endtask

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stimulus
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hA5C3_0F96;
        pats[3] = 32'h1234_5678;

        // Reset state: inputs held at zero, outputs must be zero (R3).
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        compare("R3", 32'h0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // Register-sourced amounts 0..40 and large values, all codes (R1 R3..R8).
        for (int k = 0; k < 8; k++)
            for (int p = 0; p < 4; p++)
                for (int c = 0; c < 2; c++) begin
                    for (int n = 0; n <= 40; n++)
                        run_one(k, 1'b1, 31 - (n % 32), n, 1'b1, pats[p], c[0]);
                    run_one(k, 1'b1, 0, 200, 1'b0, pats[p], c[0]);
                    run_one(k, 1'b1, 0, 255, 1'b0, pats[p], c[0]);
                end

        // Immediate amounts with the zero-immediate flag clear and set (R9).
        for (int k = 0; k < 8; k++)
            for (int p = 0; p < 4; p++)
                for (int c = 0; c < 2; c++)
                    for (int z = 0; z < 2; z++)
                        for (int n = 0; n < 32; n++)
                            run_one(k, 1'b0, n, 255 - n, z[0], pats[p], c[0]);

        // R2: the unselected amount source has no effect.
        run_one(0, 1'b1, 9, 4, 1'b0, 32'h0000_0001, 1'b0);
        compare("R2", 32'h0000_0010, 1'b0);
        run_one(0, 1'b0, 3, 200, 1'b0, 32'h0000_0001, 1'b0);
        compare("R2", 32'h0000_0008, 1'b0);

        // R10: value plus value shifted left by 2 gives five times the value.
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            kind = 3'd0; use_reg = 1'b0; imm_amt = 5'd2; zspec = 1'b1;
            op_a = pats[p]; cin = 1'b0;
            #(CLK_PERIOD/4);
            checks++;
            if (32'(op_a + result) !== 32'(pats[p] * 32'd5)) begin
                errors++;
                $display("FAIL R10 a=%h : got sum %h expected %h",
                         op_a, 32'(op_a + result), 32'(pats[p] * 32'd5));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule